// File: doc/BRIEF.md
# Serial Configuration Handshake Sequencer

This block drives the pin-level load sequence of a slave-serial configuration port on a programmable device. A single `start` pulse opens a load. The block pulses the device's program line and then follows the device's initialisation line as it falls and rises again. It next clocks the payload out bit by bit and waits for the device's completion line. Each of the three handshake waits has its own timeout and its own failure code.

Payload comes from a producer outside the block through a valid/ready beat stream. In byte mode each beat carries eight bits. In packed mode each beat carries one already-expanded bit, and a fixed 16-bit lead-in word goes out before the first beat. The host sees two things: a busy flag for the whole run, and a result code that stays in place until the next start.

Top module: `cfg_load_seq`

## Requirements
- R1: After reset, and at idle, the program pin is inactive, the configuration clock and data pins are high, `busy` is 0, `res_code` is 0 and `pl_ready` is 0.
- R2: A `start` pulse at idle makes the program pin active (low by default) and `busy` high from the next cycle. If the synchronised init input does not go low before the timeout, the run ends with `res_code` = 3'b111 (-1) and the program pin inactive.
- R3: Once init is seen low, the program pin is released. If init does not return high before the timeout, the run ends with `res_code` = 3'b110 (-2).
- R4: After the last payload bit, the block waits for the completion input. Seeing it high ends the run with `res_code` = 3'b000. A timeout ends it with 3'b101 (-3).
- R5: Every bit follows the same order. The clock goes low with data set to the bit. The clock rises while data is unchanged. Data then returns high while the clock stays high.
- R6: In byte mode (`comp_mode` = 0 at start) each accepted `pl_data` byte is sent MSB first, eight bits per beat.
- R7: In packed mode (`comp_mode` = 1 at start) the 16 bits of 0xFF then 0x20 are sent MSB first. After them, each beat sends only `pl_data[0]`, and bits 7:1 have no effect.
- R8: Each wait times out after POLL_LIMIT ticks of a 1 ms timebase derived from CLK_HZ, counted from entry to that wait, and not before.
- R9: `busy` stays high from start until a code is posted. A start pulse while busy is ignored. The code reads 0 while busy and holds its final value until the next start.
- R10: `pl_ready` is high only during the payload phase. No configuration clock edge occurs during the handshake waits.
- R11: With PROG_ACT_HIGH = 1 the program pin has the opposite level in every state.
- R12: The final beat is marked by `pl_last`. After its bits the block requests no further beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a load when idle |
| comp_mode | input | 1 | Payload format latched at start: 0 byte beats, 1 single-bit beats |
| pl_valid | input | 1 | Payload beat valid |
| pl_data | input | 8 | Payload beat; only bit 0 is used in packed mode |
| pl_last | input | 1 | Marks the final payload beat |
| pl_ready | output | 1 | Block accepts a beat this cycle |
| cfg_prog | output | 1 | Program line to the device |
| cfg_cclk | output | 1 | Configuration clock to the device |
| cfg_dout | output | 1 | Configuration data to the device |
| cfg_init | input | 1 | Device initialisation status, asynchronous |
| cfg_done | input | 1 | Device completion status, asynchronous |
| busy | output | 1 | A load is in progress |
| res_code | output | 3 | Result, two's complement: 0 ok, -1, -2, -3 per failing wait |

## Verification
The hardest case to reach is the second and third timeout. Each needs the first handshake to succeed, and the third also needs the whole payload to drain while completion is held low. The bench models the device with directed tasks. It watches the program pin and drops init only after the pin goes active. It raises init after release only when the test wants success. It counts clock rising edges to decide when the payload has fully left the block before it drives or withholds completion. A short timebase (eight cycles per tick) keeps each timeout a few dozen cycles long, so the bench can check that the block is still busy partway through the window and has posted its code after it.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_PLO   = 3'd1,
    S_PHI   = 3'd2,
    S_LEAD  = 3'd3,
    S_DATA  = 3'd4,
    S_DONEW = 3'd5
  } seq_state_t;

  localparam logic [2:0]  RC_OK      = 3'b000;
  localparam logic [2:0]  RC_INIT_LO = 3'b111;
  localparam logic [2:0]  RC_INIT_HI = 3'b110;
  localparam logic [2:0]  RC_DONE    = 3'b101;
  localparam logic [15:0] LEAD_WORD  = 16'hFF20;
  localparam int          LEAD_BITS  = 16;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int       W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/cfg_tick_gen.sv
module cfg_tick_gen #(
  parameter int DIV   = 50000,
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic expired
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int TW = $clog2(LIMIT + 1);

  logic [CW-1:0] cyc_q;
  logic [TW-1:0] nt_q;

  assign expired = (nt_q == TW'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cyc_q <= '0;
      nt_q  <= '0;
    end else if (!expired) begin
      if (cyc_q == CW'(DIV - 1)) begin
        cyc_q <= '0;
        nt_q  <= nt_q + 1'b1;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  // R8: the limit is reached only at the end of a full tick period
  assert_expire_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(expired) |-> ($past(cyc_q) == CW'(DIV - 1)));
endmodule

// File: rtl/cfg_bit_tx.sv
module cfg_bit_tx #(
  parameter int PH_CYC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic bit_in,
  output logic busy_o,
  output logic cclk_o,
  output logic dout_o
);
  localparam int HW = (PH_CYC > 1) ? $clog2(PH_CYC) : 1;

  logic [1:0]    ph_q;
  logic [HW-1:0] hc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cclk_o <= 1'b1;
      dout_o <= 1'b1;
      ph_q   <= 2'd0;
      hc_q   <= '0;
    end else if (!busy_o) begin
      if (go) begin
        busy_o <= 1'b1;
        cclk_o <= 1'b0;
        dout_o <= bit_in;
        ph_q   <= 2'd0;
        hc_q   <= '0;
      end
    end else if (hc_q == HW'(PH_CYC - 1)) begin
      hc_q <= '0;
      ph_q <= ph_q + 2'd1;
      case (ph_q)
        2'd1:    cclk_o <= 1'b1;
        2'd2:    dout_o <= 1'b1;
        2'd3:    busy_o <= 1'b0;
        default: ;
      endcase
    end else begin
      hc_q <= hc_q + 1'b1;
    end
  end

  // R5: data holds across the rising clock edge
  assert_rise_data_stable_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(cclk_o) |-> (dout_o == $past(dout_o)));
  // R5: data returns high only while the clock is high
  assert_data_release_high_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_o) |-> cclk_o);
endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
  import cfg_load_pkg::*;
#(
  parameter int CLK_HZ        = 50_000_000,
  parameter int POLL_LIMIT    = 4,
  parameter int PH_CYC        = 2,
  parameter bit PROG_ACT_HIGH = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       comp_mode,
  input  logic       pl_valid,
  input  logic [7:0] pl_data,
  input  logic       pl_last,
  output logic       pl_ready,
  output logic       cfg_prog,
  output logic       cfg_cclk,
  output logic       cfg_dout,
  input  logic       cfg_init,
  input  logic       cfg_done,
  output logic       busy,
  output logic [2:0] res_code
);
  localparam int DIV = CLK_HZ / 1000;
  localparam int NW  = $clog2(LEAD_BITS + 1);

  seq_state_t    st_q, st_nxt;
  logic [15:0]   sreg_q;
  logic [NW-1:0] cnt_q;
  logic          last_q, mode_q;
  logic          init_s, done_s;
  logic          tmo, tmr_clr, in_wait;
  logic          tx_busy, tx_go, accept;
  logic          fin;
  logic [2:0]    fin_code;

  cfg_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .rst(rst), .d({cfg_init, cfg_done}), .q({init_s, done_s})
  );

  assign in_wait = (st_q == S_PLO) || (st_q == S_PHI) || (st_q == S_DONEW);
  assign tmr_clr = (st_nxt != st_q) || !in_wait;

  cfg_tick_gen #(.DIV(DIV), .LIMIT(POLL_LIMIT)) u_tick (
    .clk(clk), .rst(rst), .clr(tmr_clr), .expired(tmo)
  );

  assign tx_go    = ((st_q == S_LEAD) || (st_q == S_DATA)) && (cnt_q != '0) && !tx_busy;
  assign pl_ready = (st_q == S_DATA) && (cnt_q == '0) && !tx_busy && !last_q;
  assign accept   = pl_ready && pl_valid;

  cfg_bit_tx #(.PH_CYC(PH_CYC)) u_tx (
    .clk(clk), .rst(rst), .go(tx_go), .bit_in(sreg_q[15]),
    .busy_o(tx_busy), .cclk_o(cfg_cclk), .dout_o(cfg_dout)
  );

  always_comb begin
    st_nxt   = st_q;
    fin      = 1'b0;
    fin_code = RC_OK;
    case (st_q)
      S_IDLE:  if (start) st_nxt = S_PLO;
      S_PLO: begin
        if (!init_s) st_nxt = S_PHI;
        else if (tmo) begin st_nxt = S_IDLE; fin = 1'b1; fin_code = RC_INIT_LO; end
      end
      S_PHI: begin
        if (init_s) st_nxt = mode_q ? S_LEAD : S_DATA;
        else if (tmo) begin st_nxt = S_IDLE; fin = 1'b1; fin_code = RC_INIT_HI; end
      end
      S_LEAD:  if (cnt_q == '0 && !tx_busy) st_nxt = S_DATA;
      S_DATA:  if (cnt_q == '0 && !tx_busy && last_q) st_nxt = S_DONEW;
      S_DONEW: begin
        if (done_s) begin st_nxt = S_IDLE; fin = 1'b1; fin_code = RC_OK; end
        else if (tmo) begin st_nxt = S_IDLE; fin = 1'b1; fin_code = RC_DONE; end
      end
      default: st_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_IDLE;
      sreg_q   <= '0;
      cnt_q    <= '0;
      last_q   <= 1'b0;
      mode_q   <= 1'b0;
      busy     <= 1'b0;
      res_code <= RC_OK;
      cfg_prog <= ~PROG_ACT_HIGH;
    end else begin
      st_q     <= st_nxt;
      cfg_prog <= (st_nxt == S_PLO) ? PROG_ACT_HIGH : ~PROG_ACT_HIGH;
      if (st_q == S_IDLE && start) begin
        busy     <= 1'b1;
        res_code <= RC_OK;
        mode_q   <= comp_mode;
        last_q   <= 1'b0;
        cnt_q    <= '0;
      end
      if (fin) begin
        busy     <= 1'b0;
        res_code <= fin_code;
      end
      if (st_q == S_PHI && st_nxt == S_LEAD) begin
        sreg_q <= LEAD_WORD;
        cnt_q  <= NW'(LEAD_BITS);
      end
      if (tx_go) begin
        sreg_q <= {sreg_q[14:0], 1'b0};
        cnt_q  <= cnt_q - 1'b1;
      end
      if (accept) begin
        last_q <= pl_last;
        if (mode_q) begin
          sreg_q <= {pl_data[0], 15'd0};
          cnt_q  <= NW'(1);
        end else begin
          sreg_q <= {pl_data, 8'd0};
          cnt_q  <= NW'(8);
        end
      end
    end
  end

  // R2: program line is active only inside a run
  assert_prog_within_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_prog == PROG_ACT_HIGH) |-> busy);
  // R10: beats are requested only with program released and clock parked high
  assert_ready_in_payload_R10: assert property (@(posedge clk) disable iff (rst)
    pl_ready |-> (busy && cfg_cclk && (cfg_prog != PROG_ACT_HIGH)));
  // R9: a new run starts with a cleared code
  assert_code_cleared_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (res_code == RC_OK));
  // R9: an idle block with no start keeps its code
  assert_code_held_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(res_code));
endmodule

// File: tb/sim_cfg_load_seq.sv
module sim_cfg_load_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, comp_mode = 1'b0, pl_valid = 1'b0, pl_last = 1'b0;
  logic [7:0] pl_data = 8'h00;
  logic cfg_init = 1'b1, cfg_done = 1'b0;
  logic pl_ready, cfg_prog, cfg_cclk, cfg_dout, busy;
  logic [2:0] res_code;
  logic r1_ready, r1_prog, r1_cclk, r1_dout, r1_busy;
  logic [2:0] r1_code;

  int total = 0, bad = 0;
  logic cap [0:255];
  int ncap = 0, r5_bad = 0;
  logic saw_ready = 1'b0;
  logic prev_cclk = 1'b1, prev_dout = 1'b1;

  always #10 clk = ~clk;

  cfg_load_seq #(.CLK_HZ(8000), .POLL_LIMIT(4), .PH_CYC(1), .PROG_ACT_HIGH(1'b0)) u0 (
    .clk(clk), .rst(rst), .start(start), .comp_mode(comp_mode), .pl_valid(pl_valid),
    .pl_data(pl_data), .pl_last(pl_last), .pl_ready(pl_ready), .cfg_prog(cfg_prog),
    .cfg_cclk(cfg_cclk), .cfg_dout(cfg_dout), .cfg_init(cfg_init), .cfg_done(cfg_done),
    .busy(busy), .res_code(res_code));

  cfg_load_seq #(.CLK_HZ(8000), .POLL_LIMIT(4), .PH_CYC(1), .PROG_ACT_HIGH(1'b1)) u1 (
    .clk(clk), .rst(rst), .start(start), .comp_mode(comp_mode), .pl_valid(pl_valid),
    .pl_data(pl_data), .pl_last(pl_last), .pl_ready(r1_ready), .cfg_prog(r1_prog),
    .cfg_cclk(r1_cclk), .cfg_dout(r1_dout), .cfg_init(cfg_init), .cfg_done(cfg_done),
    .busy(r1_busy), .res_code(r1_code));

  // capture data at every rising configuration clock, and check R5 ordering
  always @(negedge clk) begin
    if (!prev_cclk && cfg_cclk) begin
      if (ncap < 256) cap[ncap] = cfg_dout;
      if (cfg_dout != prev_dout) r5_bad = r5_bad + 1;
      ncap = ncap + 1;
    end
    if (pl_ready) saw_ready = 1'b1;
    prev_cclk = cfg_cclk;
    prev_dout = cfg_dout;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic mode);
    @(negedge clk); start = 1'b1; comp_mode = mode;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 2000) begin @(negedge clk); cyc++; end
  endtask

  // device model: drop init after program goes active, raise it after release
  task automatic handshake_ok();
    int n;
    n = 0;
    while (cfg_prog && n < 50) begin @(negedge clk); n++; end
    cfg_init = 1'b0;
    n = 0;
    while (!cfg_prog && n < 50) begin @(negedge clk); n++; end
    chk("R3 program released after init low", int'(cfg_prog), 1);
    @(negedge clk); cfg_init = 1'b1;
  endtask

  task automatic send_beat(input logic [7:0] d, input logic lst);
    int n;
    pl_valid = 1'b1; pl_data = d; pl_last = lst;
    n = 0;
    while (!pl_ready && n < 500) begin @(negedge clk); n++; end
    @(negedge clk);
    pl_valid = 1'b0; pl_last = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 program inactive", int'(cfg_prog), 1);
    chk("R1 clock high", int'(cfg_cclk), 1);
    chk("R1 data high", int'(cfg_dout), 1);
    chk("R1 busy low", int'(busy), 0);
    chk("R1 code zero", int'(res_code), 0);
    chk("R1 ready low", int'(pl_ready), 0);
    chk("R11 active-high variant idle level", int'(r1_prog), 0);
  endtask

  task automatic t_init_low_timeout();
    int c, base;
    base = ncap;
    pulse_start(1'b0);
    chk("R2 program active", int'(cfg_prog), 0);
    chk("R11 active-high variant asserted", int'(r1_prog), 1);
    chk("R2 busy after start", int'(busy), 1);
    repeat (20) @(negedge clk);
    chk("R8 no early timeout", int'(busy), 1);
    wait_idle(c);
    chk("R2 init-low timeout code", int'(res_code), 7);
    chk("R8 timeout within window", int'(c < 30), 1);
    chk("R2 program released on failure", int'(cfg_prog), 1);
    chk("R10 no clock edge in handshake", ncap - base, 0);
  endtask

  task automatic t_init_high_timeout();
    int c, n, base;
    base = ncap;
    saw_ready = 1'b0;
    pulse_start(1'b0);
    n = 0;
    while (cfg_prog && n < 50) begin @(negedge clk); n++; end
    cfg_init = 1'b0;
    n = 0;
    while (!cfg_prog && n < 50) begin @(negedge clk); n++; end
    chk("R3 program released after init low", int'(cfg_prog), 1);
    wait_idle(c);
    chk("R3 init-high timeout code", int'(res_code), 6);
    chk("R10 no clock edge in handshake", ncap - base, 0);
    chk("R10 no ready outside payload", int'(saw_ready), 0);
    cfg_init = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_byte_ok();
    int c, n, base;
    logic [15:0] exp;
    exp = 16'hA53C;
    base = ncap;
    cfg_done = 1'b0;
    pulse_start(1'b0);
    handshake_ok();
    send_beat(8'hA5, 1'b0);
    send_beat(8'h3C, 1'b1);
    n = 0;
    while ((ncap - base) < 16 && n < 500) begin @(negedge clk); n++; end
    repeat (6) @(negedge clk);
    chk("R12 no request after last beat", int'(pl_ready), 0);
    chk("R4 still waiting for completion", int'(busy), 1);
    cfg_done = 1'b1;
    wait_idle(c);
    chk("R4 success code", int'(res_code), 0);
    chk("R6 bit count", ncap - base, 16);
    for (int i = 0; i < 16; i++)
      chk($sformatf("R6 byte bit %0d", i), int'(cap[base + i]), int'(exp[15 - i]));
    chk("R5 data stable at clock rise", r5_bad, 0);
    cfg_done = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_done_timeout();
    int c, n, base;
    base = ncap;
    pulse_start(1'b0);
    handshake_ok();
    send_beat(8'h81, 1'b1);
    n = 0;
    while ((ncap - base) < 8 && n < 500) begin @(negedge clk); n++; end
    wait_idle(c);
    chk("R4 completion timeout code", int'(res_code), 5);
    chk("R6 single byte bits", ncap - base, 8);
    chk("R6 first bit of 0x81", int'(cap[base]), 1);
    chk("R6 last bit of 0x81", int'(cap[base + 7]), 1);
  endtask

  task automatic t_packed();
    int c, n, base;
    logic [19:0] exp;
    exp = {16'hFF20, 4'b1011};
    base = ncap;
    pulse_start(1'b1);
    handshake_ok();
    send_beat(8'hE1, 1'b0);
    send_beat(8'hFE, 1'b0);
    send_beat(8'h01, 1'b0);
    send_beat(8'h81, 1'b1);
    n = 0;
    while ((ncap - base) < 20 && n < 800) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    cfg_done = 1'b1;
    wait_idle(c);
    chk("R7 packed success code", int'(res_code), 0);
    chk("R7 lead-in plus payload count", ncap - base, 20);
    for (int i = 0; i < 20; i++)
      chk($sformatf("R7 packed bit %0d", i), int'(cap[base + i]), int'(exp[19 - i]));
    chk("R5 data stable at clock rise", r5_bad, 0);
    cfg_done = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_busy_hold();
    int c;
    pulse_start(1'b0);
    repeat (5) @(negedge clk);
    pulse_start(1'b0);
    chk("R9 start while busy ignored, program still active", int'(cfg_prog), 0);
    wait_idle(c);
    chk("R9 run ended by first timeout", int'(res_code), 7);
    chk("R9 not restarted by second start", int'(c < 30), 1);
    repeat (20) @(negedge clk);
    chk("R9 code held at idle", int'(res_code), 7);
    chk("R9 busy low at idle", int'(busy), 0);
    pulse_start(1'b0);
    chk("R9 code cleared by new start", int'(res_code), 0);
    chk("R9 busy set by new start", int'(busy), 1);
    wait_idle(c);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_init_low_timeout();
    t_init_high_timeout();
    t_byte_ok();
    t_done_timeout();
    t_packed();
    t_busy_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule